// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This unit carries out one memory access for each request it receives. In the same cycle it forms the effective address from a base value and an offset. The offset is either a zero-extended immediate or a 32-bit offset register. Three addressing forms are supported: plain offset, pre-indexed and post-indexed. For the two indexed forms the unit also produces the updated base for the register file to write back.

Stores go out on a simple synchronous memory port. The data is replicated across the byte lanes and a byte-lane strobe marks which lanes to write. Loads return their word one cycle after the request. The unit then picks the addressed byte or halfword from that word and zero-extends or sign-extends it. A misaligned halfword or word, or the reserved size code, issues no memory request and no writeback. It is reported as an error instead.

Top module: `mem_xfer_unit`

## Requirements
- R1: With mode code 0 (offset) or the reserved mode code 3, mem_addr equals req_base plus the offset, modulo 2^32, and wb_en stays low. The offset is req_imm zero-extended when req_use_reg is 0, and req_offreg when it is 1.
- R2: With mode code 1 (pre-indexed), mem_addr is base plus offset. wb_en is high and wb_value equals that same address.
- R3: With mode code 2 (post-indexed), mem_addr is the unmodified req_base. wb_en is high and wb_value is base plus offset.
- R4: Size codes are 0 for byte, 1 for halfword and 2 for word. The strobe mem_be is 4'b1111 for a word. For a halfword it is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a byte it is the one-hot value 1 << addr[1:0]. The same strobe rules apply to loads and to stores.
- R5: mem_we is high only for store requests. mem_wdata repeats the low byte four times for a byte store and the low halfword twice for a halfword store. A word store passes the data unchanged.
- R6: For a load, resp_data is valid in the cycle after the request and is taken from that cycle's mem_rdata. A byte comes from lane addr[1:0] in little-endian order, and a halfword from the upper half when addr[1] is 1. req_signed set means sign-extend; clear means zero-extend. A word is returned whole.
- R7: A halfword at an odd address, a word whose addr[1:0] is not 0, or size code 3 raises no mem_req and no wb_en. The next cycle shows resp_err high with resp_data 0.
- R8: resp_valid is high in exactly the cycle after each cycle with req_valid high. For a store, resp_err and resp_data are 0.
- R9: While req_valid is low, mem_req and wb_en are low, whatever the other request inputs are.
- R10: During and right after reset, resp_valid and resp_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_signed | input | 1 | Sign-extend a byte or halfword load |
| req_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 treated as offset |
| req_use_reg | input | 1 | Take the offset from req_offreg instead of req_imm |
| req_base | input | 32 | Base register value |
| req_imm | input | IMM_W | Unsigned immediate offset |
| req_offreg | input | 32 | Offset register value |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Access byte address |
| mem_be | output | 4 | Byte-lane strobe |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_req |
| wb_en | output | 1 | Base writeback valid |
| wb_value | output | 32 | New base value |
| resp_valid | output | 1 | Response cycle marker |
| resp_err | output | 1 | Alignment or size error |
| resp_data | output | 32 | Extended load data |

## Verification
The bench builds the unit with IMM_W set to 8. This puts the largest immediate, 255, within a small table vector, so zero extension of the immediate can be checked at lane 3 of a byte access. The base values include one near the top of the address space, so the 32-bit wrap of the sum is reached. The vectors cover every byte lane, both halfword positions, each sign option, all four mode codes and every misalignment class.

// File: rtl/mxu_pkg.sv
package mxu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE    = 2'd1,
    AM_POST   = 2'd2,
    AM_RSVD   = 2'd3
  } addr_mode_e;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  // True when the access cannot be issued as requested.
  function automatic logic bad_access(xfer_size_e sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return lo[0];
      SZ_WORD: return |lo;
      default: return 1'b1;
    endcase
  endfunction

  // Strobe bit for one byte lane.
  function automatic logic lane_hit(xfer_size_e sz, logic [1:0] lo, int lane);
    case (sz)
      SZ_BYTE: return (int'(lo) == lane);
      SZ_HALF: return (lo[1] == (lane >= 2));
      default: return 1'b1;
    endcase
  endfunction

  // Store byte placed on one lane.
  function automatic logic [7:0] lane_byte(xfer_size_e sz, logic [DATA_W-1:0] d, int lane);
    case (sz)
      SZ_BYTE: return d[7:0];
      SZ_HALF: return (lane % 2 == 0) ? d[7:0] : d[15:8];
      default: return d[8*lane +: 8];
    endcase
  endfunction

  // Pick and extend load data from the returned word.
  function automatic logic [DATA_W-1:0] load_extract(logic [DATA_W-1:0] w, xfer_size_e sz,
                                                     logic sgn, logic [1:0] lo);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[{lo, 3'b000} +: 8];
    h = lo[1] ? w[31:16] : w[15:0];
    case (sz)
      SZ_BYTE: return {{24{sgn & b[7]}}, b};
      SZ_HALF: return {{16{sgn & h[15]}}, h};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/mxu_agen.sv
module mxu_agen
  import mxu_pkg::*;
#(
  parameter int IMM_W = 12
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] offreg,
  input  logic              use_reg,
  input  addr_mode_e        mode,
  output logic [DATA_W-1:0] acc_addr,
  output logic [DATA_W-1:0] sum_addr,
  output logic              indexed
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] offset;

  always_comb begin
    offset   = use_reg ? offreg : {{PAD_W{1'b0}}, imm};
    sum_addr = base + offset;
    indexed  = (mode == AM_PRE) || (mode == AM_POST);
    acc_addr = (mode == AM_POST) ? base : sum_addr;
  end
endmodule

// File: rtl/mxu_wrfmt.sv
module mxu_wrfmt
  import mxu_pkg::*;
(
  input  xfer_size_e        size,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata_rep
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g]              = lane_hit(size, lo, g);
    assign wdata_rep[8*g +: 8] = lane_byte(size, wdata, g);
  end
endmodule

// File: rtl/mxu_rdext.sv
module mxu_rdext
  import mxu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_load,
  input  logic              take_err,
  input  xfer_size_e        size,
  input  logic              sgn,
  input  logic [1:0]        lo,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_data
);
  logic       ld_q;
  logic       sgn_q;
  logic [1:0] lo_q;
  xfer_size_e size_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      ld_q       <= 1'b0;
      sgn_q      <= 1'b0;
      lo_q       <= 2'b00;
      size_q     <= SZ_BYTE;
    end else begin
      resp_valid <= take;
      resp_err   <= take & take_err;
      ld_q       <= take & take_load;
      sgn_q      <= sgn;
      lo_q       <= lo;
      size_q     <= size;
    end
  end

  assign resp_data = ld_q ? load_extract(mem_rdata, size_q, sgn_q, lo_q) : '0;

  a_r8_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> resp_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> !resp_valid);
  a_r7_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_data == '0) && resp_valid);
  a_r6_sign_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && ld_q && sgn_q && size_q == SZ_BYTE) |-> (resp_data[31:8] == {24{resp_data[7]}}));
  a_r6_zero_half: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && ld_q && !sgn_q && size_q == SZ_HALF) |-> (resp_data[31:16] == 16'h0));
endmodule

// File: rtl/mem_xfer_unit.sv
module mem_xfer_unit
  import mxu_pkg::*;
#(
  parameter int IMM_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [1:0]        req_mode,
  input  logic              req_use_reg,
  input  logic [31:0]       req_base,
  input  logic [IMM_W-1:0]  req_imm,
  input  logic [31:0]       req_offreg,
  input  logic [31:0]       req_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              wb_en,
  output logic [31:0]       wb_value,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [31:0]       resp_data
);
  xfer_size_e size;
  addr_mode_e mode;
  logic       indexed;
  logic       bad;
  logic       go;

  assign size = xfer_size_e'(req_size);
  assign mode = addr_mode_e'(req_mode);

  mxu_agen #(.IMM_W(IMM_W)) agen_i (
    .base     (req_base),
    .imm      (req_imm),
    .offreg   (req_offreg),
    .use_reg  (req_use_reg),
    .mode     (mode),
    .acc_addr (mem_addr),
    .sum_addr (wb_value),
    .indexed  (indexed)
  );

  assign bad     = bad_access(size, mem_addr[1:0]);
  assign go      = req_valid & ~bad;
  assign mem_req = go;
  assign mem_we  = go & req_store;
  assign wb_en   = go & indexed;

  mxu_wrfmt wrfmt_i (
    .size      (size),
    .lo        (mem_addr[1:0]),
    .wdata     (req_wdata),
    .be        (mem_be),
    .wdata_rep (mem_wdata)
  );

  mxu_rdext rdext_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (req_valid),
    .take_load  (go & ~req_store),
    .take_err   (bad),
    .size       (size),
    .sgn        (req_signed),
    .lo         (mem_addr[1:0]),
    .mem_rdata  (mem_rdata),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .resp_data  (resp_data)
  );

  a_r3_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_mode == 2'd2) |-> (mem_addr == req_base) && wb_en);
  a_r2_pre_wb_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_mode == 2'd1) |-> wb_en && (wb_value == mem_addr));
  a_r1_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 2'd0 || req_mode == 2'd3) |-> !wb_en);
  a_r4_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'd2) |-> (mem_addr[1:0] == 2'b00) && (mem_be == 4'hF));
  a_r4_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && req_size == 2'd0) |-> ($countones(mem_be) == 1));
  a_r7_reserved_size: assert property (@(posedge clk) disable iff (!rst_n)
    (req_size == 2'd3) |-> !mem_req && !wb_en);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_req && !wb_en && !mem_we);
  a_r5_we_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> req_store && mem_req);
endmodule

// File: tb/mem_xfer_unit_tb_top.sv
module mem_xfer_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IMM_W      = 8;

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic        sg;
    logic [1:0]  md;
    logic        ur;
    logic [31:0] base;
    logic [7:0]  imm;
    logic [31:0] offr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        e_req;
    logic [31:0] e_addr;
    logic [3:0]  e_be;
    logic [31:0] e_wd;
    logic        e_wb;
    logic [31:0] e_wbv;
    logic        e_err;
    logic [31:0] e_data;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'd2,1'b0,2'd0,1'b0,32'h1000,8'h04,32'h0,32'h0,32'hDEADBEEF,1'b1,32'h1004,4'hF,32'h0,1'b0,32'h0,1'b0,32'hDEADBEEF},
    '{1'b0,2'd0,1'b1,2'd0,1'b1,32'h2000,8'h00,32'h3,32'h0,32'h80AA5511,1'b1,32'h2003,4'h8,32'h0,1'b0,32'h0,1'b0,32'hFFFFFF80},
    '{1'b0,2'd0,1'b0,2'd1,1'b0,32'h0100,8'h02,32'h0,32'h0,32'h12F45678,1'b1,32'h0102,4'h4,32'h0,1'b1,32'h0102,1'b0,32'h000000F4},
    '{1'b0,2'd1,1'b1,2'd2,1'b0,32'h0200,8'h08,32'h0,32'h0,32'h80017FFE,1'b1,32'h0200,4'h3,32'h0,1'b1,32'h0208,1'b0,32'h00007FFE},
    '{1'b0,2'd1,1'b1,2'd0,1'b1,32'h0300,8'h00,32'h2,32'h0,32'h80017FFE,1'b1,32'h0302,4'hC,32'h0,1'b0,32'h0,1'b0,32'hFFFF8001},
    '{1'b0,2'd1,1'b0,2'd0,1'b0,32'h0302,8'h00,32'h0,32'h0,32'h80017FFE,1'b1,32'h0302,4'hC,32'h0,1'b0,32'h0,1'b0,32'h00008001},
    '{1'b1,2'd0,1'b0,2'd2,1'b1,32'h0403,8'h00,32'h1,32'h123456AB,32'h0,1'b1,32'h0403,4'h8,32'hABABABAB,1'b1,32'h0404,1'b0,32'h0},
    '{1'b1,2'd1,1'b0,2'd1,1'b0,32'h0500,8'h06,32'h0,32'hFFFFC3D2,32'h0,1'b1,32'h0506,4'hC,32'hC3D2C3D2,1'b1,32'h0506,1'b0,32'h0},
    '{1'b1,2'd2,1'b0,2'd0,1'b0,32'h0600,8'h10,32'h0,32'hCAFEF00D,32'h0,1'b1,32'h0610,4'hF,32'hCAFEF00D,1'b0,32'h0,1'b0,32'h0},
    '{1'b0,2'd2,1'b0,2'd1,1'b0,32'h0700,8'h02,32'h0,32'h0,32'h11111111,1'b0,32'h0,4'h0,32'h0,1'b0,32'h0,1'b1,32'h0},
    '{1'b1,2'd1,1'b0,2'd0,1'b1,32'h0801,8'h00,32'h0,32'h5555,32'h0,1'b0,32'h0,4'h0,32'h0,1'b0,32'h0,1'b1,32'h0},
    '{1'b0,2'd3,1'b0,2'd0,1'b0,32'h0900,8'h00,32'h0,32'h0,32'h22222222,1'b0,32'h0,4'h0,32'h0,1'b0,32'h0,1'b1,32'h0},
    '{1'b0,2'd2,1'b0,2'd1,1'b1,32'hFFFFFFFC,8'h00,32'h8,32'h0,32'h55AA55AA,1'b1,32'h4,4'hF,32'h0,1'b1,32'h4,1'b0,32'h55AA55AA},
    '{1'b0,2'd2,1'b0,2'd3,1'b0,32'h0A00,8'h04,32'h0,32'h0,32'h0BADF00D,1'b1,32'h0A04,4'hF,32'h0,1'b0,32'h0,1'b0,32'h0BADF00D},
    '{1'b0,2'd0,1'b0,2'd0,1'b0,32'h1000,8'hFF,32'h0,32'h0,32'h9A000000,1'b1,32'h10FF,4'h8,32'h0,1'b0,32'h0,1'b0,32'h0000009A}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, req_use_reg = 1'b0;
  logic [1:0] req_size = 2'd0, req_mode = 2'd0;
  logic [31:0] req_base = '0, req_offreg = '0, req_wdata = '0, mem_rdata = '0;
  logic [IMM_W-1:0] req_imm = '0;
  logic mem_req, mem_we, wb_en, resp_valid, resp_err;
  logic [31:0] mem_addr, mem_wdata, wb_value, resp_data;
  logic [3:0] mem_be;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mem_xfer_unit #(.IMM_W(IMM_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_mode(req_mode),
    .req_use_reg(req_use_reg), .req_base(req_base), .req_imm(req_imm),
    .req_offreg(req_offreg), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_value(wb_value),
    .resp_valid(resp_valid), .resp_err(resp_err), .resp_data(resp_data)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    return (m == 2'd1) ? "R2" : (m == 2'd2) ? "R3" : "R1";
  endfunction

  initial begin
    // R10: reset state
    #(CLK_PERIOD * 2 + 1);
    chk("R10", "resp_valid in reset", {31'b0, resp_valid}, 32'h0);
    chk("R10", "resp_err in reset", {31'b0, resp_err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R10", "resp_valid after reset", {31'b0, resp_valid}, 32'h0);

    // R9: idle with indexed mode and a word address held on the inputs
    req_mode = 2'd1; req_size = 2'd2; req_base = 32'h40; req_imm = 8'h4; req_store = 1'b1;
    #1;
    chk("R9", "mem_req idle", {31'b0, mem_req}, 32'h0);
    chk("R9", "wb_en idle", {31'b0, wb_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_store = VECS[i].st; req_size = VECS[i].sz;
      req_signed = VECS[i].sg; req_mode = VECS[i].md; req_use_reg = VECS[i].ur;
      req_base = VECS[i].base; req_imm = VECS[i].imm; req_offreg = VECS[i].offr;
      req_wdata = VECS[i].wd;
      #1;
      chk("R7", $sformatf("v%0d mem_req", i), {31'b0, mem_req}, {31'b0, VECS[i].e_req});
      if (VECS[i].e_req) begin
        chk(mode_tag(VECS[i].md), $sformatf("v%0d mem_addr", i), mem_addr, VECS[i].e_addr);
        chk("R4", $sformatf("v%0d mem_be", i), {28'b0, mem_be}, {28'b0, VECS[i].e_be});
        chk("R5", $sformatf("v%0d mem_we", i), {31'b0, mem_we}, {31'b0, VECS[i].st});
        if (VECS[i].st)
          chk("R5", $sformatf("v%0d mem_wdata", i), mem_wdata, VECS[i].e_wd);
      end
      chk(mode_tag(VECS[i].md), $sformatf("v%0d wb_en", i), {31'b0, wb_en}, {31'b0, VECS[i].e_wb});
      if (VECS[i].e_wb)
        chk(mode_tag(VECS[i].md), $sformatf("v%0d wb_value", i), wb_value, VECS[i].e_wbv);
      @(negedge clk);
      req_valid = 1'b0;
      mem_rdata = VECS[i].rd;
      #1;
      chk("R8", $sformatf("v%0d resp_valid", i), {31'b0, resp_valid}, 32'h1);
      chk("R7", $sformatf("v%0d resp_err", i), {31'b0, resp_err}, {31'b0, VECS[i].e_err});
      chk("R6", $sformatf("v%0d resp_data", i), resp_data, VECS[i].e_data);
    end

    // R8: response lasts a single cycle
    @(negedge clk);
    #1;
    chk("R8", "resp_valid drops", {31'b0, resp_valid}, 32'h0);

    // R8: back-to-back requests give back-to-back responses
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'd0; req_signed = 1'b1;
    req_mode = 2'd0; req_use_reg = 1'b0; req_base = 32'h20; req_imm = 8'h1;
    @(negedge clk);
    mem_rdata = 32'h0000_7F00;
    #1;
    chk("R8", "first of pair valid", {31'b0, resp_valid}, 32'h1);
    chk("R6", "signed byte positive", resp_data, 32'h0000007F);
    req_base = 32'h21;
    @(negedge clk);
    req_valid = 1'b0;
    mem_rdata = 32'h0000_8000;
    #1;
    chk("R8", "second of pair valid", {31'b0, resp_valid}, 32'h1);
    chk("R6", "signed byte lane2 zero", resp_data, 32'h00000000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule